// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one flash bus operation each time software asks for one. Software first loads a command byte or an address byte into a holding register, then writes a control word in which exactly one start bit is set. The block then drives the flash strobes for that phase: a command latch, an address latch, a train of write pulses for a page program, or a train of read pulses for a page read, an ID read or a status read. When the phase is over it raises a sticky completion flag. For program and read phases the flag waits until the flash ready/busy line, sampled through a synchronizer, shows ready. Software never has to watch that line itself.

The completion flag drives an interrupt output unless a mask bit is set. A configuration register holds the chip-enable control, the interrupt mask, the byte-order selection, the pages-per-block code and a self-clearing soft reset. A buffer-select register holds the chip-select number and a buffer index. Write access is a simple one-cycle strobe. Read access is combinational from the read address.

Top module: `flash_op_seq`

## Requirements
- R1: After reset the control register (offset 4) reads 0, `irq` is low, `fl_we_n` and `fl_re_n` are high, and every `fl_ce_n` bit is high.
- R2: A control write whose bits 5:0 equal 000001 (command) gives one `fl_we_n` low pulse of STROBE_CYC clocks. During the pulse `fl_cle` is high, `fl_dq_oe` is high and `fl_dq_out` equals the low byte of the command holding register (offset 0). Afterwards control bit 15 is set.
- R3: A control write with only bit 1 set (address) gives one `fl_we_n` pulse of STROBE_CYC clocks. During the pulse `fl_ale` is high and `fl_dq_out` equals the low byte of the address holding register (offset 1). Afterwards bit 15 is set.
- R4: Only bit 2 (program) gives DATA_BEATS `fl_we_n` pulses with `fl_cle`, `fl_ale` and `fl_dq_oe` low. Bit 15 is set only after `fl_rb_n` has been seen high.
- R5: Only bit 3 (page read) gives DATA_BEATS `fl_re_n` pulses. Bit 15 is set only after `fl_rb_n` has been seen high.
- R6: Only bit 4 (ID read) gives ID_BEATS `fl_re_n` pulses, and only bit 5 (status read) gives one. Both complete while `fl_rb_n` is low.
- R7: Bit 15 stays set until a control write carries 0 in bit 15; a control write with bit 15 at 1 leaves it unchanged. While an operation runs, control bits 5:0 read back its start bit.
- R8: `irq` equals control bit 15 AND NOT configuration (offset 3) bit 4.
- R9: A control write is ignored as a start while an operation runs, and also when bits 5:0 do not hold exactly one 1. Either way no strobe is produced.
- R10: Writing configuration bit 6 returns the sequencer to idle and clears bit 15. Bit 6 reads 1 for RST_CYC clocks after the write, then 0.
- R11: With configuration bit 7 set, `fl_ce_n[k]` is low for k equal to buffer-select (offset 2) bits 6:5, and every other bit is high. With bit 7 clear, all bits are high. Buffer-select bits 6:5 and 2:0 read back as written.
- R12: `blk_pages` equals 32 shifted left by configuration bits 10:9, and `swap_bytes` follows configuration bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| fl_ce_n | output | NUM_CS | Chip enables, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_out | output | 8 | Byte driven to the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_rb_n | input | 1 | Flash ready (1) / busy (0) |
| blk_pages | output | 9 | Decoded pages per erase block |
| swap_bytes | output | 1 | Byte-order selection |

## Verification
The hardest case to reach is a register write that lands while an operation is still in progress. This covers both a second start request and a soft reset, and either one is only possible during the short strobe train or a wait on ready. The bench holds `fl_rb_n` low, so a program operation stays parked in its ready wait. In that window it issues a competing start write and later a soft reset, and it checks the control readback and the absence of strobes. A scoreboard queue of expected strobe pulses catches any extra, missing or mis-shaped pulse.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
   // register offsets
   localparam logic [2:0] OFS_CMD  = 3'd0;
   localparam logic [2:0] OFS_ADR  = 3'd1;
   localparam logic [2:0] OFS_BUF  = 3'd2;
   localparam logic [2:0] OFS_CFG  = 3'd3;
   localparam logic [2:0] OFS_CTRL = 3'd4;

   // control word bits
   localparam int OP_CMD  = 0;
   localparam int OP_ADR  = 1;
   localparam int OP_PROG = 2;
   localparam int OP_READ = 3;
   localparam int OP_ID   = 4;
   localparam int OP_STAT = 5;
   localparam int OP_W    = 6;
   localparam int FLAG_BIT = 15;

   // configuration bits
   localparam int CFG_MASK = 4;
   localparam int CFG_BE   = 5;
   localparam int CFG_RST  = 6;
   localparam int CFG_CE   = 7;
   localparam int CFG_PPB  = 9;

   typedef enum logic [2:0] {
      S_IDLE, S_STROBE, S_GAP, S_WAITRDY, S_DONE
   } seq_state_t;
endpackage

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
   import flash_seq_pkg::*;
#(
   parameter int RST_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [15:0]       wr_data,
   input  logic [2:0]        rd_addr,
   output logic [15:0]       rd_data,
   input  logic              busy,
   input  logic              done,
   input  logic [OP_W-1:0]   op_run,
   output logic              start,
   output logic [OP_W-1:0]   start_op,
   output logic              soft_rst,
   output logic [7:0]        cmd_byte,
   output logic [7:0]        adr_byte,
   output logic [1:0]        cs_sel,
   output logic              cfg_ce,
   output logic              cfg_mask,
   output logic              cfg_be,
   output logic [1:0]        cfg_ppb,
   output logic              flag,
   output logic              irq
);
   localparam int RC_W = $clog2(RST_CYC + 1);

   logic [15:0]     cmd_q, adr_q;
   logic [1:0]      cs_q;
   logic [2:0]      bidx_q;
   logic [RC_W-1:0] rst_cnt;
   logic            ctrl_wr, cfg_wr;

   assign ctrl_wr  = wr_en && (wr_addr == OFS_CTRL);
   assign cfg_wr   = wr_en && (wr_addr == OFS_CFG);
   assign soft_rst = (rst_cnt != '0);
   assign start    = ctrl_wr && $onehot(wr_data[OP_W-1:0]) && !busy && !soft_rst;
   assign start_op = wr_data[OP_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         adr_q    <= '0;
         cs_q     <= '0;
         bidx_q   <= '0;
         cfg_ce   <= 1'b0;
         cfg_mask <= 1'b0;
         cfg_be   <= 1'b0;
         cfg_ppb  <= '0;
         rst_cnt  <= '0;
      end else begin
         if (wr_en && wr_addr == OFS_CMD) cmd_q <= wr_data;
         if (wr_en && wr_addr == OFS_ADR) adr_q <= wr_data;
         if (wr_en && wr_addr == OFS_BUF) begin
            cs_q   <= wr_data[6:5];
            bidx_q <= wr_data[2:0];
         end
         if (cfg_wr) begin
            cfg_ce   <= wr_data[CFG_CE];
            cfg_mask <= wr_data[CFG_MASK];
            cfg_be   <= wr_data[CFG_BE];
            cfg_ppb  <= wr_data[CFG_PPB+1:CFG_PPB];
         end
         if (cfg_wr && wr_data[CFG_RST]) rst_cnt <= RC_W'(RST_CYC);
         else if (soft_rst)              rst_cnt <= rst_cnt - 1'b1;
      end
   end

   // sticky completion flag: set wins over a clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            flag <= 1'b0;
      else if (soft_rst)                     flag <= 1'b0;
      else if (done)                         flag <= 1'b1;
      else if (ctrl_wr && !wr_data[FLAG_BIT]) flag <= 1'b0;
   end

   assign irq      = flag && !cfg_mask;
   assign cmd_byte = cmd_q[7:0];
   assign adr_byte = adr_q[7:0];
   assign cs_sel   = cs_q;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         OFS_CMD:  rd_data = cmd_q;
         OFS_ADR:  rd_data = adr_q;
         OFS_BUF:  rd_data = {9'd0, cs_q, 2'd0, bidx_q};
         OFS_CFG:  rd_data = {5'd0, cfg_ppb, 1'b0, cfg_ce, soft_rst, cfg_be, cfg_mask, 4'd0};
         OFS_CTRL: rd_data = {flag, 9'd0, op_run};
         default:  rd_data = '0;
      endcase
   end

   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(ctrl_wr && !wr_data[FLAG_BIT]) && !soft_rst) |=> flag);
   a_r10_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !flag);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
   import flash_seq_pkg::*;
#(
   parameter int STROBE_CYC  = 3,
   parameter int DATA_BEATS  = 4,
   parameter int ID_BEATS    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [OP_W-1:0] start_op,
   input  logic            soft_rst,
   input  logic            fl_rb_n,
   output logic            busy,
   output logic            done,
   output logic [OP_W-1:0] op_run,
   output logic            strobe
);
   localparam int CNT_W  = $clog2(STROBE_CYC) + 1;
   localparam int MAXB   = (DATA_BEATS > ID_BEATS) ? DATA_BEATS : ID_BEATS;
   localparam int BEAT_W = $clog2(MAXB) + 1;

   seq_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [BEAT_W-1:0] beats, start_beats;
   logic [OP_W-1:0]   op_q;
   logic              rdy_s, needs_rdy;

   if (STROBE_CYC < 1) begin : g_chk_strobe
      $error("STROBE_CYC must be at least 1");
   end
   if (DATA_BEATS < 1 || ID_BEATS < 1) begin : g_chk_beats
      $error("beat counts must be at least 1");
   end

   // ready/busy synchronizer, depth chosen by parameter
   if (SYNC_STAGES == 0) begin : g_nosync
      assign rdy_s = fl_rb_n;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sq <= '0;
         else        sq <= {sq[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], fl_rb_n} >> (SYNC_STAGES == 1 ? 1 : 0);
      end
      assign rdy_s = sq[SYNC_STAGES-1];
   end

   always_comb begin
      start_beats = BEAT_W'(1);
      if (start_op[OP_PROG] || start_op[OP_READ]) start_beats = BEAT_W'(DATA_BEATS);
      else if (start_op[OP_ID])                    start_beats = BEAT_W'(ID_BEATS);
   end

   assign needs_rdy = op_q[OP_PROG] || op_q[OP_READ];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         cnt   <= '0;
         beats <= '0;
         op_q  <= '0;
      end else if (soft_rst) begin
         state <= S_IDLE;
         cnt   <= '0;
         beats <= '0;
         op_q  <= '0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               op_q  <= start_op;
               cnt   <= CNT_W'(STROBE_CYC - 1);
               beats <= start_beats - 1'b1;
               state <= S_STROBE;
            end
            S_STROBE: if (cnt == '0) state <= S_GAP;
                      else           cnt   <= cnt - 1'b1;
            S_GAP: if (beats == '0) begin
               state <= needs_rdy ? S_WAITRDY : S_DONE;
            end else begin
               beats <= beats - 1'b1;
               cnt   <= CNT_W'(STROBE_CYC - 1);
               state <= S_STROBE;
            end
            S_WAITRDY: if (rdy_s) state <= S_DONE;
            S_DONE: begin
               op_q  <= '0;
               state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy   = (state != S_IDLE);
   assign done   = (state == S_DONE);
   assign strobe = (state == S_STROBE);
   assign op_run = op_q;

   a_r9_op_held: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_STROBE || state == S_GAP || state == S_WAITRDY) && !soft_rst)
      |=> $stable(op_q));
   a_r4_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (done && needs_rdy) |-> $past(rdy_s));
   a_r10_idle_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (state == S_IDLE));
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
   import flash_seq_pkg::*;
#(
   parameter int NUM_CS      = 4,
   parameter int STROBE_CYC  = 3,
   parameter int DATA_BEATS  = 4,
   parameter int ID_BEATS    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int RST_CYC     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [15:0]       wr_data,
   input  logic [2:0]        rd_addr,
   output logic [15:0]       rd_data,
   output logic              irq,
   output logic [NUM_CS-1:0] fl_ce_n,
   output logic              fl_cle,
   output logic              fl_ale,
   output logic              fl_we_n,
   output logic              fl_re_n,
   output logic [7:0]        fl_dq_out,
   output logic              fl_dq_oe,
   input  logic              fl_rb_n,
   output logic [8:0]        blk_pages,
   output logic              swap_bytes
);
   if (NUM_CS < 1 || NUM_CS > 4) begin : g_chk_cs
      $error("NUM_CS must be 1..4");
   end
   if (RST_CYC < 1) begin : g_chk_rst
      $error("RST_CYC must be at least 1");
   end

   logic            busy, done, start, soft_rst, strobe, flag;
   logic [OP_W-1:0] op_run, start_op;
   logic [7:0]      cmd_byte, adr_byte;
   logic [1:0]      cs_sel, cfg_ppb;
   logic            cfg_ce, cfg_mask, cfg_be;

   flash_seq_regs #(.RST_CYC(RST_CYC)) u_regs (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
      .busy, .done, .op_run, .start, .start_op, .soft_rst,
      .cmd_byte, .adr_byte, .cs_sel, .cfg_ce, .cfg_mask, .cfg_be,
      .cfg_ppb, .flag, .irq
   );

   flash_seq_fsm #(
      .STROBE_CYC(STROBE_CYC), .DATA_BEATS(DATA_BEATS),
      .ID_BEATS(ID_BEATS), .SYNC_STAGES(SYNC_STAGES)
   ) u_fsm (
      .clk, .rst_n, .start, .start_op, .soft_rst, .fl_rb_n,
      .busy, .done, .op_run, .strobe
   );

   assign fl_cle    = strobe && op_run[OP_CMD];
   assign fl_ale    = strobe && op_run[OP_ADR];
   assign fl_dq_oe  = strobe && (op_run[OP_CMD] || op_run[OP_ADR]);
   assign fl_dq_out = op_run[OP_CMD] ? cmd_byte : adr_byte;
   assign fl_we_n   = !(strobe && (op_run[OP_CMD] || op_run[OP_ADR] || op_run[OP_PROG]));
   assign fl_re_n   = !(strobe && (op_run[OP_READ] || op_run[OP_ID] || op_run[OP_STAT]));

   for (genvar k = 0; k < NUM_CS; k++) begin : g_ce
      assign fl_ce_n[k] = !(cfg_ce && cs_sel == 2'(k));
   end

   assign blk_pages  = 9'd32 << cfg_ppb;
   assign swap_bytes = cfg_be;

   a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n && !fl_re_n));
   a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mask |-> !irq);
   a_r11_single_ce: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~fl_ce_n));
   a_r6_no_latch_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_re_n |-> (!fl_cle && !fl_ale && !fl_dq_oe));
endmodule

// File: tb/flash_op_seq_tb.sv
module flash_op_seq_tb_top;
   localparam int STROBE = 3;
   localparam int DBEATS = 4;
   localparam int IBEATS = 2;
   localparam int RSTC   = 4;

   typedef struct packed {
      logic [1:0] kind;   // 0 cle, 1 ale, 2 write data, 3 read
      logic [7:0] dbyte;
      logic [7:0] len;
   } pulse_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_addr = '0, rd_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic irq, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe, swap_bytes;
   logic [3:0] fl_ce_n;
   logic [7:0] fl_dq_out;
   logic [8:0] blk_pages;
   logic fl_rb_n = 1'b1;

   int checks = 0, errors = 0;
   pulse_t exp_q[$];
   string  tag_q[$];

   always #4 clk = ~clk;

   flash_op_seq #(.NUM_CS(4), .STROBE_CYC(STROBE), .DATA_BEATS(DBEATS),
                  .ID_BEATS(IBEATS), .SYNC_STAGES(2), .RST_CYC(RSTC)) dut_i (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .irq,
      .fl_ce_n, .fl_cle, .fl_ale, .fl_we_n, .fl_re_n, .fl_dq_out, .fl_dq_oe,
      .fl_rb_n, .blk_pages, .swap_bytes
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic push(input logic [1:0] k, input logic [7:0] b, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back('{kind: k, dbyte: b, len: 8'(STROBE)});
         tag_q.push_back(tag);
      end
   endtask

   task automatic wait_flag(input int maxc, output bit got);
      logic [15:0] d;
      got = 1'b0;
      for (int i = 0; i < maxc; i++) begin
         @(negedge clk);
         rd(3'd4, d);
         if (d[15]) begin got = 1'b1; break; end
      end
   endtask

   // monitor: rebuild strobe pulses and compare with the scoreboard
   bit in_pulse = 0;
   pulse_t cur;
   always @(negedge clk) begin
      if (rst_n && (!fl_we_n || !fl_re_n)) begin
         if (!in_pulse) begin
            in_pulse   = 1;
            cur.kind   = fl_cle ? 2'd0 : fl_ale ? 2'd1 : !fl_we_n ? 2'd2 : 2'd3;
            cur.dbyte  = fl_dq_oe ? fl_dq_out : 8'h00;
            cur.len    = 8'd0;
         end
         cur.len = cur.len + 8'd1;
      end else if (in_pulse) begin
         in_pulse = 0;
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected strobe", 32'(cur), 32'h0);
         end else begin
            pulse_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(cur == e, t, 32'(cur), 32'(e));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      bit got;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd4, d);
      check(d == 16'h0 && !irq && fl_we_n && fl_re_n && fl_ce_n == 4'hF,
            "R1 reset state", {d, 11'd0, irq, fl_ce_n}, 32'h000F);

      // R2 command cycle
      reg_wr(3'd0, 16'h1270);
      push(2'd0, 8'h70, 1, "R2 command pulse");
      reg_wr(3'd4, 16'h0001);
      wait_flag(40, got);
      check(got, "R2 completion flag", got, 1);
      check(irq, "R8 irq follows flag", irq, 1);

      // R3 address cycle
      reg_wr(3'd1, 16'h00A5);
      push(2'd1, 8'hA5, 1, "R3 address pulse");
      reg_wr(3'd4, 16'h0002);
      wait_flag(40, got);
      check(got, "R3 completion flag", got, 1);

      // R7 sticky flag, R8 mask
      reg_wr(3'd4, 16'h8000);
      rd(3'd4, d);
      check(d == 16'h8000, "R7 write of one keeps flag", d, 16'h8000);
      reg_wr(3'd3, 16'h0010);
      check(!irq, "R8 masked irq", irq, 0);
      reg_wr(3'd3, 16'h0000);
      check(irq, "R8 unmasked irq", irq, 1);
      reg_wr(3'd4, 16'h0000);
      rd(3'd4, d);
      check(d == 16'h0000 && !irq, "R7 write of zero clears flag", d, 0);

      // R5 page read
      push(2'd3, 8'h00, DBEATS, "R5 read pulse");
      reg_wr(3'd4, 16'h0008);
      wait_flag(60, got);
      check(got, "R5 completion flag", got, 1);

      // R6 ID and status with busy flash
      fl_rb_n = 1'b0;
      push(2'd3, 8'h00, IBEATS, "R6 id pulse");
      reg_wr(3'd4, 16'h0010);
      wait_flag(60, got);
      check(got, "R6 id completes while busy", got, 1);
      push(2'd3, 8'h00, 1, "R6 status pulse");
      reg_wr(3'd4, 16'h0020);
      wait_flag(40, got);
      check(got, "R6 status completes while busy", got, 1);

      // R4 program waits on ready, R9 start while running ignored
      push(2'd2, 8'h00, DBEATS, "R4 program pulse");
      reg_wr(3'd4, 16'h0004);
      repeat (30) @(negedge clk);
      rd(3'd4, d);
      check(d == 16'h0004, "R4 no flag while busy, R7 op readback", d, 16'h0004);
      reg_wr(3'd4, 16'h0001);
      repeat (6) @(negedge clk);
      rd(3'd4, d);
      check(d == 16'h0004, "R9 start ignored while running", d, 16'h0004);
      fl_rb_n = 1'b1;
      wait_flag(20, got);
      check(got, "R4 flag after ready", got, 1);

      // R10 soft reset during a parked program, flag kept by 0x8004 write
      fl_rb_n = 1'b0;
      push(2'd2, 8'h00, DBEATS, "R4 program pulse");
      reg_wr(3'd4, 16'h8004);
      repeat (25) @(negedge clk);
      rd(3'd4, d);
      check(d == 16'h8004, "R7 flag kept while running", d, 16'h8004);
      reg_wr(3'd3, 16'h0040);
      rd(3'd3, d);
      check(d[6], "R10 reset bit reads one", d, 16'h0040);
      @(negedge clk);
      rd(3'd4, d);
      check(d == 16'h0000, "R10 idle and flag cleared", d, 0);
      repeat (RSTC - 1) @(negedge clk);
      rd(3'd3, d);
      check(d == 16'h0000, "R10 reset bit self clears", d, 0);
      fl_rb_n = 1'b1;
      repeat (10) @(negedge clk);
      rd(3'd4, d);
      check(d == 16'h0000, "R10 no completion after reset", d, 0);

      // R9 not exactly one start bit
      reg_wr(3'd4, 16'h0003);
      repeat (12) @(negedge clk);
      rd(3'd4, d);
      check(d == 16'h0000, "R9 two start bits ignored", d, 0);

      // R11 chip enable and select
      reg_wr(3'd2, 16'h0045);
      rd(3'd2, d);
      check(d == 16'h0045, "R11 buffer select readback", d, 16'h0045);
      check(fl_ce_n == 4'hF, "R11 ce off", fl_ce_n, 4'hF);
      reg_wr(3'd3, 16'h0080);
      check(fl_ce_n == 4'b1011, "R11 ce on select 2", fl_ce_n, 4'b1011);

      // R12 config fields
      reg_wr(3'd3, 16'h0620);
      check(blk_pages == 9'd256 && swap_bytes, "R12 256 pages, swap", {blk_pages, swap_bytes}, {9'd256, 1'b1});
      reg_wr(3'd3, 16'h0200);
      check(blk_pages == 9'd64 && !swap_bytes, "R12 64 pages", {blk_pages, swap_bytes}, {9'd64, 1'b0});

      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule